// File: doc/BRIEF.md
# Pipeline memory access stage

This block is the data-memory step of an in-order processor pipeline, placed between execute and writeback. It holds one instruction record at a time. A record has an opcode and three operand slots. Upstream offers a record with a valid/ready handshake. Downstream takes it with a valid/OK handshake. Opcodes other than load and store cross the stage in one cycle and are not changed. A load or a store raises a word request on a simple request/response memory port. The record stays in the stage until memory answers with OK.

Operand slots are reused in place. A load takes its word address from slot 1, and the word that comes back replaces slot 2. A store takes its address from slot 2 and its data from slot 1. A squash input empties the stage and is passed straight to the downstream stage. Each record that leaves carries the cycle count of the cycle in which it left.

Top module: `mem_stage`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0, `mem_req` is 0 and `in_ready` is 1.
- R2: A load (opcode 3'd1) drives `mem_addr` from the low ADDR_W bits of slot 1 and drives `mem_we` at 0. When the record is offered downstream, slot 2 holds the `mem_rdata` word that was present in the OK cycle. The opcode, slot 1 and slot 3 are not changed.
- R3: A store (opcode 3'd2) drives `mem_addr` from the low ADDR_W bits of slot 2, `mem_wdata` from slot 1, and `mem_we` at 1. The record is forwarded unchanged.
- R4: `mem_req` rises in the cycle after a load or store is accepted. It stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle in which `mem_ok` is 1. The record is not offered downstream before that cycle.
- R5: Any other opcode raises no memory request. It is offered downstream, unchanged, in the cycle after it is accepted.
- R6: A record leaves only in a cycle in which `out_valid` and `out_ok` are both 1 and `squash` is 0. Until then it is held stable. Records leave in the order in which they were accepted, and every record that is not squashed is delivered.
- R7: `in_ready` is 1 exactly when `squash` is 0 and the stage is either empty or its record leaves in that cycle.
- R8: `squash_out` follows `squash` in the same cycle. After a cycle with `squash` at 1, `out_valid` and `mem_req` are 0, and the discarded record is never delivered.
- R9: `out_stamp` is the number of clock edges since reset was released, modulo 2^CNT_W. It is 0 in the first cycle after reset and is read in the cycle in which the record leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers a record |
| in_ready | output | 1 | Stage accepts the offered record this cycle |
| in_op | input | 3 | Opcode (1 load, 2 store, others pass through) |
| in_s1 | input | DATA_W | Operand slot 1 |
| in_s2 | input | DATA_W | Operand slot 2 |
| in_s3 | input | DATA_W | Operand slot 3 |
| out_valid | output | 1 | Record ready to leave |
| out_ok | input | 1 | Downstream takes the record |
| out_op | output | 3 | Held opcode |
| out_s1 | output | DATA_W | Held slot 1 |
| out_s2 | output | DATA_W | Held slot 2 (load result after a load) |
| out_s3 | output | DATA_W | Held slot 3 |
| out_stamp | output | CNT_W | Cycle count at departure |
| squash | input | 1 | Empty the stage |
| squash_out | output | 1 | Squash passed to the downstream stage |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ok | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ok |

## Verification
The bench sets the memory latency at random between 0 and 3 cycles and puts garbage on `mem_rdata` in every cycle without OK. A stage that captured read data too early would then return the wrong word in slot 2. Downstream OK is withheld at random, so a stage that dropped or replaced a held record under backpressure would break the order of the sequence numbers carried in slot 3. A first pass stores to every address and a second pass loads from every address. If the address and data slots were swapped, the loaded words would not match. Two squashes are applied, one while a load waits for memory and one while a pass-through record waits downstream. A stage that kept the record would deliver it or keep requesting. A stage that accepted input during the squash would be caught by the check on `in_ready`.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;
  parameter int OP_W = 3;
  localparam logic [OP_W-1:0] OP_LOAD  = 3'd1;
  localparam logic [OP_W-1:0] OP_STORE = 3'd2;

  function automatic logic op_is_mem(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/mem_stage_ctl.sv
module mem_stage_ctl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_is_mem,
  input  logic squash,
  input  logic out_ok,
  input  logic mem_ok,
  output logic in_ready,
  output logic accept,
  output logic out_valid,
  output logic mem_req,
  output logic mem_done
);
  logic full_q;
  logic done_q;
  logic fire;

  assign out_valid = full_q & done_q;
  assign mem_req   = full_q & ~done_q;
  assign fire      = out_valid & out_ok & ~squash;
  assign in_ready  = ~squash & (~full_q | fire);
  assign accept    = in_valid & in_ready;
  assign mem_done  = mem_req & mem_ok;

  always_ff @(posedge clk) begin
    if (rst || squash) begin
      full_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        done_q <= ~in_is_mem;
      end else begin
        if (fire) full_q <= 1'b0;
        if (mem_done) done_q <= 1'b1;
      end
    end
  end

  // R4: request stays up until memory answers
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ok && !squash) |=> mem_req);
  // R6: an offered record stays offered under backpressure
  a_r6_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ok && !squash) |=> out_valid);
  // R8: squash empties the stage
  a_r8_squash_clear: assert property (@(posedge clk) disable iff (rst)
    squash |=> (!out_valid && !mem_req));
endmodule

// File: rtl/mem_stage_rec.sv
module mem_stage_rec #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 3,
  parameter int N_SLOT  = 3,
  parameter int RES_IDX = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           accept,
  input  logic [OP_W-1:0]                in_op,
  input  logic [N_SLOT-1:0][DATA_W-1:0]  in_slot,
  input  logic                           wr_res,
  input  logic [DATA_W-1:0]              res_data,
  output logic [OP_W-1:0]                op_q,
  output logic [N_SLOT-1:0][DATA_W-1:0]  slot_q
);
  always_ff @(posedge clk) begin
    if (rst)         op_q <= '0;
    else if (accept) op_q <= in_op;
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    if (i == RES_IDX) begin : g_res
      always_ff @(posedge clk) begin
        if (rst)         slot_q[i] <= '0;
        else if (accept) slot_q[i] <= in_slot[i];
        else if (wr_res) slot_q[i] <= res_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)         slot_q[i] <= '0;
        else if (accept) slot_q[i] <= in_slot[i];
      end
    end
  end
endmodule

// File: rtl/mem_stage_tick.sv
module mem_stage_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // R9: one step per clock, wrapping
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/mem_stage.sv
module mem_stage
  import mem_stage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_s1,
  input  logic [DATA_W-1:0] in_s2,
  input  logic [DATA_W-1:0] in_s3,
  output logic              out_valid,
  input  logic              out_ok,
  output logic [OP_W-1:0]   out_op,
  output logic [DATA_W-1:0] out_s1,
  output logic [DATA_W-1:0] out_s2,
  output logic [DATA_W-1:0] out_s3,
  output logic [CNT_W-1:0]  out_stamp,
  input  logic              squash,
  output logic              squash_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ok,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int N_SLOT  = 3;
  localparam int IDX_S1  = 0;
  localparam int IDX_S2  = 1;
  localparam int IDX_S3  = 2;

  logic                          accept;
  logic                          mem_done;
  logic                          is_load;
  logic                          is_store;
  logic [OP_W-1:0]               op_q;
  logic [N_SLOT-1:0][DATA_W-1:0] in_slot;
  logic [N_SLOT-1:0][DATA_W-1:0] slot_q;

  assign in_slot = {in_s3, in_s2, in_s1};

  mem_stage_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_is_mem (op_is_mem(in_op)),
    .squash    (squash),
    .out_ok    (out_ok),
    .mem_ok    (mem_ok),
    .in_ready  (in_ready),
    .accept    (accept),
    .out_valid (out_valid),
    .mem_req   (mem_req),
    .mem_done  (mem_done)
  );

  mem_stage_rec #(
    .DATA_W  (DATA_W),
    .OP_W    (OP_W),
    .N_SLOT  (N_SLOT),
    .RES_IDX (IDX_S2)
  ) u_rec (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .in_op    (in_op),
    .in_slot  (in_slot),
    .wr_res   (mem_done & is_load),
    .res_data (mem_rdata),
    .op_q     (op_q),
    .slot_q   (slot_q)
  );

  mem_stage_tick #(.CNT_W(CNT_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .cnt (out_stamp)
  );

  assign is_load    = (op_q == OP_LOAD);
  assign is_store   = (op_q == OP_STORE);
  assign mem_we     = is_store;
  assign mem_addr   = is_load ? slot_q[IDX_S1][ADDR_W-1:0] : slot_q[IDX_S2][ADDR_W-1:0];
  assign mem_wdata  = slot_q[IDX_S1];
  assign squash_out = squash;
  assign out_op     = op_q;
  assign out_s1     = slot_q[IDX_S1];
  assign out_s2     = slot_q[IDX_S2];
  assign out_s3     = slot_q[IDX_S3];

  // R4: request fields do not move while waiting
  a_r4_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ok && !squash) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R2: load result lands in slot 2 and is offered next cycle
  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ok && !mem_we && !squash) |=>
      (out_valid && out_s2 == $past(mem_rdata)));
  // R6: held record is stable under backpressure
  a_r6_rec_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ok && !squash) |=>
      ($stable(out_op) && $stable(out_s1) && $stable(out_s2) && $stable(out_s3)));
endmodule

// File: tb/mem_stage_tb.sv
module mem_stage_tb;
  import mem_stage_pkg::*;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int MDEP   = 16;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] s1;
    logic [DATA_W-1:0] s2;
    logic [DATA_W-1:0] s3;
  } rec_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst;
  logic              in_valid, in_ready;
  logic [OP_W-1:0]   in_op;
  logic [DATA_W-1:0] in_s1, in_s2, in_s3;
  logic              out_valid, out_ok;
  logic [OP_W-1:0]   out_op;
  logic [DATA_W-1:0] out_s1, out_s2, out_s3;
  logic [CNT_W-1:0]  out_stamp;
  logic              squash, squash_out;
  logic              mem_req, mem_we, mem_ok;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  mem_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_s1(in_s1), .in_s2(in_s2), .in_s3(in_s3),
    .out_valid(out_valid), .out_ok(out_ok), .out_op(out_op),
    .out_s1(out_s1), .out_s2(out_s2), .out_s3(out_s3), .out_stamp(out_stamp),
    .squash(squash), .squash_out(squash_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ok(mem_ok), .mem_rdata(mem_rdata)
  );

  rec_t        stim_q[$];
  rec_t        exp_q[$];
  logic [31:0] bmem[MDEP];
  logic [31:0] shadow[MDEP];
  int checks = 0, failures = 0;
  int cyc = 0;
  int lat = -1;
  int p_ok = 100;
  int seq = 0;
  int n_out = 0;
  int n_sq = 0;
  bit m_full = 0, m_done = 1;
  rec_t m_held;
  bit hold_mem = 0, sq = 0, acc_prev = 0, finished = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [OP_W-1:0] op);
    if (op == OP_LOAD)  return "R2 load record";
    if (op == OP_STORE) return "R3 store record";
    return "R5 pass-through record";
  endfunction

  task automatic add(input logic [OP_W-1:0] op, input logic [31:0] a, input logic [31:0] b);
    rec_t r;
    r.op = op; r.s1 = a; r.s2 = b; r.s3 = seq;
    seq++;
    stim_q.push_back(r);
  endtask

  task automatic step();
    rec_t r;
    rec_t e;
    bit   exp_rdy;
    int   idx;
    @(negedge clk);
    // outputs after the last edge
    chk(out_valid === (m_full && m_done), "R6 out_valid", out_valid, m_full && m_done);
    if (m_full && m_done && exp_q.size() > 0) begin
      e = exp_q[0];
      chk({out_op, out_s1, out_s2, out_s3} === e, op_tag(e.op), {out_s2, out_s3}, {e.s2, e.s3});
    end
    chk(mem_req === (m_full && !m_done), "R4 mem_req", mem_req, m_full && !m_done);
    if (m_full && !m_done) begin
      if (m_held.op == OP_LOAD) begin
        chk(mem_addr === m_held.s1[ADDR_W-1:0] && mem_we === 1'b0, "R2 load request",
            {mem_we, mem_addr}, {1'b0, m_held.s1[ADDR_W-1:0]});
      end else begin
        chk(mem_addr === m_held.s2[ADDR_W-1:0] && mem_we === 1'b1 && mem_wdata === m_held.s1,
            "R3 store request", {mem_we, mem_addr, mem_wdata}, {1'b1, m_held.s2[ADDR_W-1:0], m_held.s1});
      end
    end
    // drive
    if (acc_prev || !in_valid) begin
      acc_prev = 0;
      if (stim_q.size() > 0 && ($urandom % 4) != 0) begin
        r = stim_q.pop_front();
        in_valid = 1'b1; in_op = r.op; in_s1 = r.s1; in_s2 = r.s2; in_s3 = r.s3;
      end else begin
        in_valid = 1'b0;
      end
    end
    out_ok    = (($urandom % 100) < p_ok);
    squash    = sq;
    mem_ok    = 1'b0;
    mem_rdata = $urandom;
    if (mem_req && !sq && !hold_mem) begin
      if (lat < 0) lat = $urandom % 4;
      if (lat == 0) begin
        mem_ok    = 1'b1;
        idx       = int'(mem_addr[3:0]);
        mem_rdata = bmem[idx];
        if (mem_we) bmem[idx] = mem_wdata;
        lat = -1;
      end else begin
        lat--;
      end
    end
    if (sq) lat = -1;
    #1;
    // events at the coming edge
    exp_rdy = !sq && (!m_full || (m_done && out_ok));
    chk(in_ready === exp_rdy, "R7 in_ready", in_ready, exp_rdy);
    chk(squash_out === sq, "R8 squash_out", squash_out, sq);
    if (sq) begin
      if (m_full) begin
        void'(exp_q.pop_front());
        n_sq++;
      end
      m_full = 0;
    end else begin
      if (m_full && m_done && out_ok) begin
        chk(out_stamp === cyc[CNT_W-1:0], "R9 stamp", out_stamp, cyc[CNT_W-1:0]);
        void'(exp_q.pop_front());
        n_out++;
        m_full = 0;
      end else if (m_full && !m_done && mem_ok) begin
        m_done = 1;
      end
      if (in_valid && exp_rdy) begin
        e.op = in_op; e.s1 = in_s1; e.s2 = in_s2; e.s3 = in_s3;
        m_held = e;
        if (in_op == OP_LOAD)  e.s2 = shadow[int'(in_s1[3:0])];
        if (in_op == OP_STORE) shadow[int'(in_s2[3:0])] = in_s1;
        exp_q.push_back(e);
        m_full = 1;
        m_done = !op_is_mem(in_op);
        acc_prev = 1;
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 5000; k++) begin
      if (stim_q.size() == 0 && !m_full && !(in_valid && !acc_prev)) break;
      step();
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MDEP; i++) begin
      bmem[i]   = 32'h1000 + i * 3;
      shadow[i] = 32'h1000 + i * 3;
    end
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_s1 = '0; in_s2 = '0; in_s3 = '0;
    out_ok = 1'b0; squash = 1'b0; mem_ok = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(mem_req === 1'b0, "R1 reset mem_req", mem_req, 0);
    chk(in_ready === 1'b1, "R1 reset in_ready", in_ready, 1);
    rst = 1'b0;

    // stores to every word, then loads of every word
    p_ok = 100;
    for (int i = 0; i < MDEP; i++) add(OP_STORE, 32'hA5000000 + i * 32'h01010101, i);
    drain();
    for (int i = 0; i < MDEP; i++) add(OP_LOAD, i, 32'hDEADBEEF);
    drain();
    for (int i = 0; i < MDEP; i++)
      chk(bmem[i] === 32'hA5000000 + i * 32'h01010101, "R3 store content", bmem[i],
          32'hA5000000 + i * 32'h01010101);

    // random mix under backpressure
    p_ok = 60;
    for (int i = 0; i < 300; i++) begin
      int kind;
      kind = $urandom % 5;
      add(OP_W'(kind == 4 ? 7 : kind), $urandom % 16, (kind == 1) ? $urandom : $urandom % 16);
    end
    drain();

    // squash while a load waits for memory
    p_ok = 100; hold_mem = 1;
    add(OP_LOAD, 5, 0);
    for (int k = 0; k < 20 && !(m_full && !m_done); k++) step();
    step(); step();
    chk(mem_req === 1'b1, "R4 waits for mem_ok", mem_req, 1);
    sq = 1; step(); sq = 0;
    step();
    chk(out_valid === 1'b0 && mem_req === 1'b0, "R8 emptied after load squash",
        {out_valid, mem_req}, 0);
    hold_mem = 0;

    // squash while a pass-through waits downstream, with input offered
    p_ok = 0;
    add(OP_W'(3), 1, 2);
    for (int k = 0; k < 20 && !m_full; k++) step();
    step(); step(); step();
    chk(out_valid === 1'b1, "R6 held under backpressure", out_valid, 1);
    add(OP_W'(0), 9, 9);
    step();
    sq = 1; step(); sq = 0;
    p_ok = 100;
    drain();

    chk(n_out == seq - n_sq, "R6 all records delivered", n_out, seq - n_sq);
    chk(n_sq == 2, "R8 squashed record count", n_sq, 2);
    finished = 1;
    summary();
    $finish;
  end
endmodule